// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit CPU and decides which of five interrupt sources the CPU services next. The five sources are two external request pins (active low), two timer overflow pulses and one serial port, whose request is the OR of a transmit flag and a receive flag. Requests from the pins and the timers are held in flags that the controller itself clears when the CPU takes that interrupt. Each source has an enable bit, and a global enable bit masks all of them. Each source can also be placed at high or low priority. Among sources at the same level, a fixed natural order decides.

The controller presents a single registered request line together with a fixed vector address. The CPU answers with a one-cycle acknowledge, and later with a one-cycle return strobe when the service routine ends. An in-service bit for each of the two levels lets a high-priority request interrupt a low-priority routine. Nothing interrupts a high-priority routine. A small write/read port gives access to the enable, priority and trigger-mode settings.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_req is low and the enable, priority and mode registers all read 0.
- R2: The register port selects a register with reg_sel, and a write takes effect on the clock edge where reg_wr is high. The registers are:
  - reg_sel 0: enable. Bit 7 is the global enable and bits 4:0 enable the sources. Bits 6:5 read 0.
  - reg_sel 1: priority, bits 4:0. Bits 7:5 read 0.
  - reg_sel 2: trigger mode, bits 1:0. Bit 0 is external 0 and bit 1 is external 1. A 0 selects low level and a 1 selects falling edge.
  - reg_rdata shows the selected register combinationally.
- R3: Source index i is also the bit position of that source in the enable and priority registers. The indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1 and 4 serial. The vector for index i is 16'h0003 + 8*i, giving 0003, 000B, 0013, 001B and 0023.
- R4: A source is presented only when both its enable bit and the global bit are 1. A timer or edge flag that arrives while masked stays latched and is presented once it is unmasked. For example, an enable value of 8'h8C lets only external 1 and timer 1 through.
- R5: When any enabled pending source has its priority bit set to 1, the lowest-index such source wins. Otherwise the lowest-index enabled pending source wins.
- R6: In level mode, an external request follows its pin after SYNC_STAGES synchronizer flops and is not latched. With the default of 2, irq_req rises 3 clock edges after the pin goes low. It falls again once the pin is released, without any acknowledge. An acknowledge does not clear it.
- R7: In edge mode, a falling edge is detected as a high sample followed by a low sample on consecutive clocks, and it is latched. irq_req rises 4 edges after the pin falls and stays up after the pin returns high.
- R8: A one-cycle timer overflow pulse sets its flag, and irq_req rises 2 edges after the pulse is driven.
- R9: An acknowledge that is sampled while irq_req is high does three things:
  - it clears the flag of the presented timer or edge source;
  - it sets the in-service bit of that source's level;
  - it forces irq_req low in the next cycle.
  An acknowledge while irq_req is low has no effect.
- R10: The serial request is the OR of ser_tx and ser_rx, and an acknowledge does not clear it.
- R11: A request is presented only when its level is above the current in-service level. High preempts low. Nothing preempts high, and a request at the same level as the routine in service waits.
- R12: A return strobe clears the high in-service bit if it is set, and otherwise clears the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | External request pins, active low (bit 0 is external 0) |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 is timer 0) |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | CPU acknowledge, one cycle |
| irq_reti | input | 1 | Return-from-interrupt strobe, one cycle |

## Verification
Each path has its own fixed latency, and the bench drives inputs and samples outputs on the falling clock edge, counting rising edges from the stimulus.
- A timer pulse must raise irq_req at exactly 2 edges. The bench checks that the line is still low one edge earlier.
- A level-mode pin must raise irq_req at exactly 3 edges, and an edge-mode pin at exactly 4 edges.
- After an acknowledge, irq_req must be low one edge later. After a return strobe, a source that is still pending must come back one edge after the strobe's edge.

The sweep over all 32 pending patterns under four enable and priority settings waits four edges, which covers the slowest path, before it compares against the winner computed in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NSRC  = 5;
   localparam int IDX_W = 3;

   localparam int SRC_EXT0 = 0;
   localparam int SRC_TMR0 = 1;
   localparam int SRC_EXT1 = 2;
   localparam int SRC_TMR1 = 3;
   localparam int SRC_SER  = 4;

   localparam logic [7:0] EN_WMASK   = 8'h9F;
   localparam int         GLB_BIT    = 7;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_PRIO   = 2'd1,
      SEL_MODE   = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic             valid;
      logic             high;
      logic [IDX_W-1:0] idx;
   } pick_t;

   // Lowest set index wins (natural order).
   function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (v[i]) r = IDX_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/irq_ext_flag.sv
module irq_ext_flag #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   latch_q;
   logic                   cur;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= pin_n;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
         end
      end
   endgenerate

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         latch_q <= 1'b0;
      end else begin
         prev_q <= cur;
         if (!edge_mode)          latch_q <= 1'b0;
         else if (prev_q && !cur) latch_q <= 1'b1;
         else if (clr)            latch_q <= 1'b0;
      end
   end

   assign req = edge_mode ? latch_q : ~cur;
endmodule

// File: rtl/irq_pulse_flag.sv
module irq_pulse_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse,
   input  logic clr,
   output logic req
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (pulse) flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
   end

   assign req = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
(
   input  logic [NSRC-1:0] pend,
   input  logic [NSRC-1:0] en_mask,
   input  logic            glb_en,
   input  logic [NSRC-1:0] prio_mask,
   input  logic            isr_hi,
   input  logic            isr_lo,
   output pick_t           pick,
   output logic            allow
);
   logic [NSRC-1:0] live;
   logic [NSRC-1:0] live_hi;

   always_comb begin
      live    = pend & en_mask & {NSRC{glb_en}};
      live_hi = live & prio_mask;
      pick.valid = |live;
      pick.high  = |live_hi;
      pick.idx   = pick.high ? lowest_set(live_hi) : lowest_set(live);
      allow = pick.valid && !isr_hi && (pick.high || !isr_lo);
   end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic take_high,
   input  logic reti,
   output logic isr_hi,
   output logic isr_lo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_hi <= 1'b0;
         isr_lo <= 1'b0;
      end else if (take) begin
         if (take_high) isr_hi <= 1'b1;
         else           isr_lo <= 1'b1;
      end else if (reti) begin
         if (isr_hi) isr_hi <= 1'b0;
         else        isr_lo <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 16,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STEP    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ext_n,
   input  logic [1:0]       tmr_ovf,
   input  logic             ser_tx,
   input  logic             ser_rx,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   input  logic             irq_ack,
   input  logic             irq_reti
);
   localparam int VEC_TOP = VEC_BASE + (NSRC - 1) * VEC_STEP;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("irq_ctrl: SYNC_STAGES must be at least 1");
      end
      if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_ctrl: VEC_W too narrow for the vector table");
      end
   endgenerate

   logic [7:0]       en_q;
   logic [NSRC-1:0]  prio_q;
   logic [1:0]       mode_q;
   logic [NSRC-1:0]  pend;
   logic [NSRC-1:0]  clr;
   logic             req_q;
   logic [IDX_W-1:0] idx_q;
   logic             high_q;
   logic             take;
   logic             isr_hi;
   logic             isr_lo;
   logic             allow;
   pick_t            pick;

   // Register port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         prio_q <= '0;
         mode_q <= '0;
      end else if (reg_wr) begin
         case (reg_sel_e'(reg_sel))
            SEL_ENABLE: en_q   <= reg_wdata & EN_WMASK;
            SEL_PRIO:   prio_q <= reg_wdata[NSRC-1:0];
            SEL_MODE:   mode_q <= reg_wdata[1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (reg_sel_e'(reg_sel))
         SEL_ENABLE: reg_rdata = en_q;
         SEL_PRIO:   reg_rdata = 8'(prio_q);
         SEL_MODE:   reg_rdata = 8'(mode_q);
         default:    reg_rdata = '0;
      endcase
   end

   // Source flags: even indices are pins, odd indices are timers
   assign take = irq_ack && req_q;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_clr
         assign clr[i] = take && (idx_q == IDX_W'(i));
      end
      for (genvar k = 0; k < 2; k++) begin : g_src
         irq_ext_flag #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (mode_q[k]),
            .clr       (clr[2*k]),
            .req       (pend[2*k])
         );
         irq_pulse_flag u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .pulse (tmr_ovf[k]),
            .clr   (clr[2*k+1]),
            .req   (pend[2*k+1])
         );
      end
   endgenerate

   assign pend[SRC_SER] = ser_tx | ser_rx;

   irq_arbiter u_arb (
      .pend      (pend),
      .en_mask   (en_q[NSRC-1:0]),
      .glb_en    (en_q[GLB_BIT]),
      .prio_mask (prio_q),
      .isr_hi    (isr_hi),
      .isr_lo    (isr_lo),
      .pick      (pick),
      .allow     (allow)
   );

   irq_nest u_nest (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_high (high_q),
      .reti      (irq_reti),
      .isr_hi    (isr_hi),
      .isr_lo    (isr_lo)
   );

   // Registered presentation to the CPU
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         idx_q  <= '0;
         high_q <= 1'b0;
      end else begin
         req_q  <= allow && !irq_ack;
         idx_q  <= pick.idx;
         high_q <= pick.high;
      end
   end

   assign irq_req = req_q;
   assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx_q);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int VEC_W    = 16,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic             irq_ack,
   input logic             irq_reti,
   input logic [VEC_W-1:0] irq_vec,
   input logic             glb_en,
   input logic             isr_hi,
   input logic             isr_lo
);
   logic legal;

   always_comb begin
      legal = 1'b0;
      for (int i = 0; i < 5; i++) begin
         if (irq_vec == VEC_W'(VEC_BASE + i * VEC_STEP)) legal = 1'b1;
      end
   end

   a_r3_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> legal);

   a_r4_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> !irq_req);

   a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);

   a_r9_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> (isr_hi || isr_lo));

   a_r11_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi |=> !irq_req);

   a_r12_pop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && isr_hi) |=> !isr_hi);

   a_r12_pop_low: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && !isr_hi && isr_lo) |=> !isr_lo);
endmodule

bind irq_ctrl irq_ctrl_chk #(
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .irq_ack  (irq_ack),
   .irq_reti (irq_reti),
   .irq_vec  (irq_vec),
   .glb_en   (en_q[7]),
   .isr_hi   (isr_hi),
   .isr_lo   (isr_lo)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_n = 2'b11;
   logic [1:0]  tmr_ovf = 2'b00;
   logic        ser_tx = 1'b0;
   logic        ser_rx = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic        irq_ack = 1'b0;
   logic        irq_reti = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   irq_ctrl u_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_n     (ext_n),
      .tmr_ovf   (tmr_ovf),
      .ser_tx    (ser_tx),
      .ser_rx    (ser_rx),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_req   (irq_req),
      .irq_vec   (irq_vec),
      .irq_ack   (irq_ack),
      .irq_reti  (irq_reti)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] d);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   task automatic ack();
      irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
   endtask

   task automatic reti();
      irq_reti = 1'b1; tick(1); irq_reti = 1'b0;
   endtask

   task automatic drain();
      repeat (12) begin
         tick(3);
         if (irq_req) begin ack(); reti(); end
      end
   endtask

   initial begin
      #(8 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      tick(2);
      // R1 reset state
      chk("R1 req", 32'(irq_req), 0);
      rd(2'd0, d); chk("R1 enable", 32'(d), 0);
      rd(2'd1, d); chk("R1 prio", 32'(d), 0);
      rd(2'd2, d); chk("R1 mode", 32'(d), 0);
      rst_n = 1'b1;
      tick(2);

      // R2 register access
      wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 enable", 32'(d), 32'h9F);
      wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 prio", 32'(d), 32'h1F);
      wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 mode", 32'(d), 32'h03);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);

      // R4 masked timer flag stays latched
      wr(2'd0, 8'h1F);
      tmr_ovf[0] = 1'b1; tick(1); tmr_ovf[0] = 1'b0; tick(4);
      chk("R4 global off", 32'(irq_req), 0);
      wr(2'd0, 8'h9F); tick(1);
      chk("R4 latched req", 32'(irq_req), 1);
      chk("R4 latched vec R3", 32'(irq_vec), 32'h000B);
      drain();

      // R8 timer latency
      tmr_ovf[1] = 1'b1; tick(1); tmr_ovf[1] = 1'b0;
      chk("R8 early", 32'(irq_req), 0);
      tick(1);
      chk("R8 req", 32'(irq_req), 1);
      chk("R8 vec", 32'(irq_vec), 32'h001B);
      drain();

      // R6 level mode latency, not cleared by ack, follows pin
      ext_n[1] = 1'b0; tick(2);
      chk("R6 early", 32'(irq_req), 0);
      tick(1);
      chk("R6 req", 32'(irq_req), 1);
      chk("R6 vec", 32'(irq_vec), 32'h0013);
      ack();
      chk("R9 drop after ack", 32'(irq_req), 0);
      reti(); tick(1);
      chk("R6 level survives ack", 32'(irq_req), 1);
      ext_n[1] = 1'b1; tick(4);
      chk("R6 release", 32'(irq_req), 0);
      drain();

      // R7 edge mode latency and clear on ack
      wr(2'd2, 8'h03);
      ext_n[0] = 1'b0; tick(2); ext_n[0] = 1'b1; tick(1);
      chk("R7 early", 32'(irq_req), 0);
      tick(1);
      chk("R7 req", 32'(irq_req), 1);
      chk("R7 vec", 32'(irq_vec), 32'h0003);
      tick(2);
      chk("R7 latched after pin high", 32'(irq_req), 1);
      ack(); reti(); tick(3);
      chk("R9 edge flag cleared", 32'(irq_req), 0);

      // R10 serial OR, not cleared by ack
      ser_tx = 1'b1; tick(1);
      chk("R10 tx req", 32'(irq_req), 1);
      chk("R10 vec", 32'(irq_vec), 32'h0023);
      ack(); reti(); tick(1);
      chk("R10 survives ack", 32'(irq_req), 1);
      ser_tx = 1'b0; ser_rx = 1'b1; tick(2);
      chk("R10 rx req", 32'(irq_req), 1);
      ser_rx = 1'b0; tick(2);
      chk("R10 off", 32'(irq_req), 0);
      drain();

      // R9 ack while idle ignored
      ack(); tick(1);
      tmr_ovf[0] = 1'b1; tick(1); tmr_ovf[0] = 1'b0; tick(1);
      chk("R9 idle ack ignored", 32'(irq_req), 1);
      drain();

      // R11 / R12 nesting: timer 1 high, rest low
      wr(2'd1, 8'h08);
      tmr_ovf[0] = 1'b1; tick(1); tmr_ovf[0] = 1'b0; tick(1);
      chk("R11 low vec", 32'(irq_vec), 32'h000B);
      ack();
      tmr_ovf[1] = 1'b1; tick(1); tmr_ovf[1] = 1'b0; tick(1);
      chk("R11 preempt req", 32'(irq_req), 1);
      chk("R11 preempt vec", 32'(irq_vec), 32'h001B);
      ack();
      ext_n[0] = 1'b0; tick(2); ext_n[0] = 1'b1; tick(4);
      chk("R11 high not preempted", 32'(irq_req), 0);
      reti(); tick(1);
      chk("R11 same level waits", 32'(irq_req), 0);
      reti(); tick(1);
      chk("R12 low popped req", 32'(irq_req), 1);
      chk("R12 vec", 32'(irq_vec), 32'h0003);
      drain();
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R3 R4 R5 sweep over all pending patterns
      for (int pass = 0; pass < 4; pass++) begin
         for (int p = 0; p < 32; p++) begin
            logic [7:0] en;
            logic [4:0] pr;
            logic [4:0] pv;
            logic [4:0] live;
            logic [4:0] sel;
            int         idx;
            pv = 5'(p);
            case (pass)
               0:       begin en = 8'h9F; pr = 5'h00; end
               1:       begin en = 8'h9F; pr = 5'(p * 7 + 3); end
               2:       begin en = 8'h8C; pr = 5'h08; end
               default: begin en = 8'h1F; pr = 5'h00; end
            endcase
            wr(2'd0, en); wr(2'd1, {3'b000, pr});
            ext_n   = ~{pv[2], pv[0]};
            ser_rx  = pv[4];
            tmr_ovf = {pv[3], pv[1]};
            tick(1);
            tmr_ovf = 2'b00;
            tick(3);
            live = pv & en[4:0] & {5{en[7]}};
            sel  = ((live & pr) != 0) ? (live & pr) : live;
            idx  = 0;
            for (int b = 4; b >= 0; b--) if (sel[b]) idx = b;
            chk("R5 sweep req R4", 32'(irq_req), 32'(sel != 0));
            if (sel != 0) chk("R5 sweep vec R3", 32'(irq_vec), 32'(3 + 8 * idx));
            ext_n = 2'b11; ser_rx = 1'b0;
            wr(2'd0, 8'h9F); wr(2'd1, 8'h00);
            drain();
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule